// File: doc/BRIEF.md
# Parallel Bus Write Sequencer

This block is a synchronous master that produces write cycles on an asynchronous 16-bit peripheral bus. The bus has two active-low strobes, a chip select and a write enable, plus a 7-bit word address. The peripheral latches a write only while both strobes are low at the same time. The write ends when either strobe rises.

A host hands over one address and one data word through a valid/ready handshake. The sequencer presents address and data, pulls both strobes low together, raises them, and holds the bus. It then waits out a recovery interval before it accepts the next request. Every analogue timing minimum (strobe overlap, data setup before the rising strobe, strobe-high gap, total cycle period, address setup and hold, data hold) is a nanosecond parameter. Each one is turned into a whole number of system clocks by rounding up, with one clock as the least value.

At the default 8 ns clock the defaults give these counts: one setup clock, four strobe-low clocks, one hold clock, a gap of at least two clocks and a fall-to-fall period of at least six clocks. A completion pulse marks the end of each write.

Top module: `pbus_write_master`

## Requirements
- R1: While reset is high and in the cycle after it, both strobes are high, the address and data buses are zero, the ready output is high and the done output is low.
- R2: A request is taken only in a clock where the ready output is high and the valid input is high. A valid request presented while ready is low causes no write and no extra completion pulse.
- R3: Chip select and write enable always carry the same level. Each write holds both low for exactly LOW clocks, where LOW is the larger of the converted overlap time and the converted data-setup time (4 at the defaults).
- R4: Between two writes both strobes stay high for at least GAP clocks, the converted strobe-high time (2 at the defaults).
- R5: From the first low clock of one write to the first low clock of the next, at least CYC clocks pass, the converted cycle time (6 at the defaults).
- R6: The accepted address and data are on the bus one clock before the strobes fall, throughout the low interval, and in the clock after the strobes rise.
- R7: Whenever ready is high, both address and data buses are zero and both strobes are high.
- R8: Done is high for exactly one clock per write, after the strobes have risen. Ready is high in the clock after done.
- R9: With valid held high continuously, successive requests are each written exactly once and in the order they were accepted.
- R10: A nanosecond minimum t becomes ceil(t / clock period) clocks, and never less than one clock, so a 0 ns minimum still costs one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host offers a write |
| req_addr | input | 7 | Word address of the offered write |
| req_data | input | 16 | Data word of the offered write |
| req_ready | output | 1 | Sequencer is idle and takes a request this clock |
| wr_done | output | 1 | One-clock pulse when a write and its recovery have finished |
| bus_cs_n | output | 1 | Chip select strobe, active low |
| bus_we_n | output | 1 | Write enable strobe, active low |
| bus_addr | output | 7 | Word address driven to the peripheral |
| bus_data | output | 16 | Data driven to the peripheral |

## Verification
The bound checker watches the bus on every clock. It checks that the two strobes match, that each low run is at least the overlap minimum, that the high gap and the fall-to-fall period meet their minimums, that data holds still while the strobes are low, that the buses are quiet while the block is idle, and how done relates to ready. Only the bench's scenarios can show the rest. These are: the right address and data reaching the bus for every address, for walking-one data and for back-to-back requests; a request offered while busy being dropped; and the exact low-run length that the rounding of the nanosecond parameters produces.

// File: rtl/pbus_wr_pkg.sv
package pbus_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_LOW     = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RECOVER = 3'd4
  } wr_state_e;

  // Round a nanosecond minimum up to whole clocks; never below one clock.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pbus_wr_timer.sv
module pbus_wr_timer
  import pbus_wr_pkg::*;
#(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  wr_state_e     state_q,
  input  wr_state_e     state_d,
  output logic [CW-1:0] in_cnt,
  output logic [CW-1:0] fall_cnt,
  output logic [CW-1:0] high_cnt
);

  logic entering_low;
  logic leaving_low;
  logic state_change;

  assign state_change = (state_d != state_q);
  assign entering_low = (state_d == ST_LOW) && (state_q != ST_LOW);
  assign leaving_low  = (state_q == ST_LOW) && (state_d != ST_LOW);

  // clocks spent in the current state, 0 in its first clock
  always_ff @(posedge clk) begin
    if (rst) begin
      in_cnt <= '0;
    end else if (state_change) begin
      in_cnt <= '0;
    end else if (in_cnt != '1) begin
      in_cnt <= in_cnt + 1'b1;
    end
  end

  // clocks since the strobes fell, 0 in the first low clock
  always_ff @(posedge clk) begin
    if (rst) begin
      fall_cnt <= '1;
    end else if (entering_low) begin
      fall_cnt <= '0;
    end else if (fall_cnt != '1) begin
      fall_cnt <= fall_cnt + 1'b1;
    end
  end

  // clocks since the strobes rose, 0 in the first high clock
  always_ff @(posedge clk) begin
    if (rst) begin
      high_cnt <= '1;
    end else if (leaving_low) begin
      high_cnt <= '0;
    end else if (high_cnt != '1) begin
      high_cnt <= high_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pbus_wr_seq.sv
module pbus_wr_seq
  import pbus_wr_pkg::*;
#(
  parameter int unsigned CW        = 4,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned LOW_CYC   = 4,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned GAP_CYC   = 2,
  parameter int unsigned CYC_CYC   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [CW-1:0] in_cnt,
  input  logic [CW-1:0] fall_cnt,
  input  logic [CW-1:0] high_cnt,
  output wr_state_e     state_q,
  output wr_state_e     state_d,
  output logic          accept,
  output logic          rec_ok
);

  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LOW_LAST   = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);
  localparam logic [CW:0]   GAP_MIN    = (CW+1)'(GAP_CYC);
  localparam logic [CW:0]   CYC_MIN    = (CW+1)'(CYC_CYC);

  logic [CW:0] high_incl;
  logic [CW:0] fall_incl;

  // counts including the present clock
  assign high_incl = {1'b0, high_cnt} + 1'b1;
  assign fall_incl = {1'b0, fall_cnt} + 1'b1;
  assign rec_ok    = (high_incl >= GAP_MIN) && (fall_incl >= CYC_MIN);
  assign accept    = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid)            state_d = ST_SETUP;
      ST_SETUP:   if (in_cnt == SETUP_LAST) state_d = ST_LOW;
      ST_LOW:     if (in_cnt == LOW_LAST)   state_d = ST_HOLD;
      ST_HOLD:    if (in_cnt == HOLD_LAST)  state_d = ST_RECOVER;
      ST_RECOVER: if (rec_ok)               state_d = ST_IDLE;
      default:                              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/pbus_wr_drive.sv
module pbus_wr_drive
  import pbus_wr_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  wr_state_e     state_d,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          cs_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  logic strobe_next_low;
  logic bus_release;

  assign strobe_next_low = (state_d == ST_LOW);
  assign bus_release     = (state_d == ST_IDLE) || (state_d == ST_RECOVER);

  // strobes come straight from flops so that they cannot glitch
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n <= 1'b1;
      we_n <= 1'b1;
    end else begin
      cs_n <= ~strobe_next_low;
      we_n <= ~strobe_next_low;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      data <= '0;
    end else if (accept) begin
      addr <= req_addr;
      data <= req_data;
    end else if (bus_release) begin
      addr <= '0;
      data <= '0;
    end
  end

endmodule

// File: rtl/pbus_write_master.sv
module pbus_write_master
  import pbus_wr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_LOW_NS      = 32,
  parameter int unsigned T_GAP_NS      = 13,
  parameter int unsigned T_CYCLE_NS    = 45,
  parameter int unsigned T_DSU_NS      = 7,
  parameter int unsigned T_ASU_NS      = 0,
  parameter int unsigned T_HOLD_NS     = 0,
  parameter int unsigned AW            = 7,
  parameter int unsigned DW            = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          req_ready,
  output logic          wr_done,
  output logic          bus_cs_n,
  output logic          bus_we_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data
);

  localparam int unsigned SETUP_CYC = ns_to_cycles(T_ASU_NS, CLK_PERIOD_NS);
  localparam int unsigned LOW_CYC   = max2(ns_to_cycles(T_LOW_NS, CLK_PERIOD_NS),
                                           ns_to_cycles(T_DSU_NS, CLK_PERIOD_NS));
  localparam int unsigned HOLD_CYC  = ns_to_cycles(T_HOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned GAP_CYC   = ns_to_cycles(T_GAP_NS, CLK_PERIOD_NS);
  localparam int unsigned CYC_CYC   = ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC   = max2(max2(max2(SETUP_CYC, LOW_CYC), max2(HOLD_CYC, GAP_CYC)),
                                           CYC_CYC);
  localparam int unsigned CW        = $clog2(MAX_CYC + 2) + 1;

  wr_state_e     state_q;
  wr_state_e     state_d;
  logic [CW-1:0] in_cnt;
  logic [CW-1:0] fall_cnt;
  logic [CW-1:0] high_cnt;

  // named internal events
  logic accept_evt;
  logic recover_ok_evt;

  pbus_wr_seq #(
    .CW(CW), .SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC),
    .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC), .CYC_CYC(CYC_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .in_cnt(in_cnt), .fall_cnt(fall_cnt), .high_cnt(high_cnt),
    .state_q(state_q), .state_d(state_d),
    .accept(accept_evt), .rec_ok(recover_ok_evt)
  );

  pbus_wr_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .state_q(state_q), .state_d(state_d),
    .in_cnt(in_cnt), .fall_cnt(fall_cnt), .high_cnt(high_cnt)
  );

  pbus_wr_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk(clk), .rst(rst), .accept(accept_evt), .state_d(state_d),
    .req_addr(req_addr), .req_data(req_data),
    .cs_n(bus_cs_n), .we_n(bus_we_n), .addr(bus_addr), .data(bus_data)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign wr_done   = (state_q == ST_RECOVER) && recover_ok_evt;

endmodule

// File: rtl/pbus_write_checks.sv
module pbus_write_checks
  import pbus_wr_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_LOW_NS      = 32,
  parameter int unsigned T_GAP_NS      = 13,
  parameter int unsigned T_CYCLE_NS    = 45,
  parameter int unsigned AW            = 7,
  parameter int unsigned DW            = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          wr_done,
  input logic          bus_cs_n,
  input logic          bus_we_n,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_data
);

  localparam int unsigned LOW_MIN = ns_to_cycles(T_LOW_NS, CLK_PERIOD_NS);
  localparam int unsigned GAP_MIN = ns_to_cycles(T_GAP_NS, CLK_PERIOD_NS);
  localparam int unsigned CYC_MIN = ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS);

  logic [7:0] low_run;
  logic [7:0] high_run;
  logic [7:0] since_fall;
  logic       seen_fall;
  logic       falling;

  assign falling = !bus_cs_n && (high_run != 8'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run    <= '0;
      high_run   <= '0;
      since_fall <= '0;
      seen_fall  <= 1'b0;
    end else begin
      low_run    <= bus_cs_n ? 8'd0 : ((low_run == 8'hFF) ? low_run : low_run + 8'd1);
      high_run   <= !bus_cs_n ? 8'd0 : ((high_run == 8'hFF) ? high_run : high_run + 8'd1);
      since_fall <= falling ? 8'd1 : ((since_fall == 8'hFF) ? since_fall : since_fall + 8'd1);
      if (falling) seen_fall <= 1'b1;
    end
  end

  assert_strobes_match_R3: assert property (@(posedge clk) disable iff (rst)
    bus_cs_n == bus_we_n);

  assert_low_width_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_cs_n && low_run != 8'd0) |-> (low_run >= 8'(LOW_MIN)));

  assert_gap_min_R4: assert property (@(posedge clk) disable iff (rst)
    (falling && seen_fall) |-> (high_run >= 8'(GAP_MIN)));

  assert_period_min_R5: assert property (@(posedge clk) disable iff (rst)
    (falling && seen_fall) |-> (since_fall >= 8'(CYC_MIN)));

  assert_data_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && low_run != 8'd0) |-> ($stable(bus_data) && $stable(bus_addr)));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bus_addr == '0 && bus_data == '0 && bus_cs_n && bus_we_n));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !wr_done);

  assert_done_then_ready_R8: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> req_ready);

  assert_done_strobes_high_R8: assert property (@(posedge clk) disable iff (rst)
    wr_done |-> (bus_cs_n && bus_we_n));

endmodule

bind pbus_write_master pbus_write_checks #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_LOW_NS(T_LOW_NS), .T_GAP_NS(T_GAP_NS),
  .T_CYCLE_NS(T_CYCLE_NS), .AW(AW), .DW(DW)
) u_checks (
  .clk(clk), .rst(rst), .req_ready(req_ready), .wr_done(wr_done),
  .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_data(bus_data)
);

// File: tb/test_pbus_write_master.sv
`timescale 1ns/1ps
module test_pbus_write_master;

  localparam int PERIOD = 8;
  localparam int MAXW   = 1024;

  // expected counts restated from the requirements: round up, floor of one
  function automatic int cyc(input int ns);
    int q;
    q = ns / PERIOD;
    if (q * PERIOD < ns) q = q + 1;
    if (q == 0) q = 1;
    return q;
  endfunction

  localparam int EXP_LOW = (cyc(32) > cyc(7)) ? cyc(32) : cyc(7);
  localparam int EXP_GAP = cyc(13);
  localparam int EXP_CYC = cyc(45);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [15:0] req_data = '0;
  logic        req_ready, wr_done, bus_cs_n, bus_we_n;
  logic [6:0]  bus_addr;
  logic [15:0] bus_data;

  pbus_write_master i_pbus_write_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_ready(req_ready), .wr_done(wr_done),
    .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_data(bus_data)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [6:0]  exp_addr [MAXW];
  logic [15:0] exp_data [MAXW];
  int nexp = 0;
  int widx = 0;
  int ndone = 0;
  bit finished = 0;
  bit mon_on = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // monitor, sampled away from the active edge
  bit   prev_low = 0, seen_fall = 0, prev_done = 0;
  int   low_len = 0, high_len = 0, since_fall = 0;
  logic [6:0]  prev_addr = '0;
  logic [15:0] prev_data = '0;

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      bit lo;
      lo = !bus_cs_n && !bus_we_n;
      if (bus_cs_n != bus_we_n) check(0, "R3 strobe match", bus_cs_n, bus_we_n);
      if (lo && !prev_low) begin
        if (seen_fall) begin
          check(high_len >= EXP_GAP, "R4 gap", high_len, EXP_GAP);
          check(since_fall >= EXP_CYC, "R5 period", since_fall, EXP_CYC);
        end
        if (widx >= nexp) check(0, "R2 unexpected write", widx, nexp);
        else check(prev_addr == exp_addr[widx] && prev_data == exp_data[widx],
                   "R6 setup", int'(prev_data), int'(exp_data[widx]));
        seen_fall = 1; since_fall = 0; low_len = 0;
      end
      if (lo) begin
        if (widx < nexp && (bus_addr != exp_addr[widx] || bus_data != exp_data[widx]))
          check(0, "R6 low", int'(bus_data), int'(exp_data[widx]));
        low_len++;
      end
      if (!lo && prev_low) begin
        check(low_len == EXP_LOW, "R3 R10 low width", low_len, EXP_LOW);
        if (widx < nexp)
          check(bus_addr == exp_addr[widx] && bus_data == exp_data[widx],
                "R6 hold", int'(bus_addr), int'(exp_addr[widx]));
        widx++; high_len = 0;
      end
      if (!lo) high_len++;
      since_fall++;
      if (wr_done) begin
        check(!prev_done, "R8 single pulse", 1, 0);
        check(!lo, "R8 done after rise", int'(lo), 0);
        ndone++;
      end
      if (prev_done) check(req_ready, "R8 ready after done", int'(req_ready), 1);
      if (req_ready && (bus_addr != 0 || bus_data != 0 || lo))
        check(0, "R7 idle quiet", int'(bus_data), 0);
      prev_low = lo; prev_done = wr_done;
      prev_addr = bus_addr; prev_data = bus_data;
    end
  end

  task automatic push(input logic [6:0] a, input logic [15:0] d);
    exp_addr[nexp] = a; exp_data[nexp] = d; nexp++;
  endtask

  // offer one request and wait until it is taken
  task automatic do_write(input logic [6:0] a, input logic [15:0] d, input bit keep);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    push(a, d);
    @(negedge clk);
    if (!keep) req_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(bus_cs_n && bus_we_n, "R1 strobes in reset", int'(bus_cs_n), 1);
    check(bus_addr == 0 && bus_data == 0, "R1 bus in reset", int'(bus_data), 0);
    check(!wr_done, "R1 done in reset", int'(wr_done), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);
    check(bus_cs_n && bus_addr == 0 && bus_data == 0, "R1 quiet after reset", int'(bus_cs_n), 1);
    mon_on = 1;

    // sweep every address with a computed data pattern
    for (int a = 0; a < 128; a++) begin
      do_write(7'(a), 16'((a * 517) ^ 16'hA5C3), 0);
      drain();
    end
    // walking-one data
    for (int b = 0; b < 16; b++) begin
      do_write(7'(b * 7), 16'(1 << b), 0);
      drain();
    end

    // R2: request offered while busy is not taken
    do_write(7'h15, 16'h1234, 0);
    check(!req_ready, "R2 busy after accept", int'(req_ready), 0);
    req_valid = 1'b1; req_addr = 7'h7F; req_data = 16'hFFFF;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    drain();

    // R9: valid held high, back-to-back requests
    for (int k = 0; k < 20; k++)
      do_write(7'(127 - k), 16'(k * 4099 + 3), 1);
    req_valid = 1'b0;
    drain();

    check(widx == nexp, "R2 R9 write count", widx, nexp);
    check(ndone == nexp, "R8 done count", ndone, nexp);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule